// File: doc/BRIEF.md
# Programmable 3x3 Colour-Space Converter

This block converts a stream of three-channel 10-bit pixels through a programmable 3x3 linear transform. Each pixel has a signed per-channel offset added to it, is multiplied by a matrix of signed fixed-point coefficients, and is rounded and scaled down. A signed per-channel output offset is then added and each channel is clamped to the 10-bit code range. Out of reset the block is loaded to turn full-range RGB into limited-range YCbCr: luma sits on a floor of 64 and both chroma channels are centred on 512. Software can load any other transform through a small 32-bit register port.

Register writes land in a staged copy of the configuration. The datapath only uses that copy after a frame-start pulse. A frame therefore always runs with one complete coefficient set, however the writes were spread over the previous frame. The pixel path is valid-qualified with a fixed three-cycle latency. When conversion is switched off, pixels pass through untouched with the same latency.

Top module: `csc_matrix3x3`

## Requirements
- R1: A pixel packs channel 0 in bits 29:20, channel 1 in bits 19:10 and channel 2 in bits 9:0. `out_valid` repeats `in_valid` exactly three clock cycles later and stays high for one cycle per input pixel.
- R2: With conversion enabled, output channel i equals floor((sum over j of C_ij * (in_j + pre_j) + 512) / 2^(10+shift)) + post_i. The coefficients are 13-bit two's complement with 10 fractional bits, so 1024 is unity gain.
- R3: Each converted output channel is clamped to the range 0 to 1023.
- R4: While bit 0 of the control register (address 10) is clear in the active configuration, the output pixel equals the input pixel bit for bit.
- R5: Register map by word address. Two fields share a word as high field at bits 16 and up and low field at bit 0. Address 0 holds pre-offsets 0 (high) and 1 (low), and address 1 holds pre-offset 2 (low). Addresses 2 to 5 hold coefficient pairs 00/01, 02/10, 11/12 and 20/21, and address 6 holds coefficient 22 (low). Address 7 holds post-offsets 0 (high) and 1 (low), and address 8 holds post-offset 2 (low). Offsets are 12-bit two's complement. A read returns the staged field bits with all other bits zero.
- R6: The right-shift field sits at bits 18:16 of address 9 and adds that many bits to the final downscale.
- R7: A write changes the staged configuration only. The staged set is copied to the active set by a `frame_start` pulse. A pixel presented in the same cycle as `frame_start` still uses the old active set.
- R8: After reset `out_valid` is low and conversion is enabled. The shift is 0 and the pre-offsets are 0. The coefficients are 186, 627, 63 / -102, -344, 448 / 448, -406, -40 (row by row), and the post-offsets are 64, 512, 512.
- R9: Pre-offsets are signed and are added to each input channel before the multiply. A negative result gives a negative product, which rounds toward minus infinity.
- R10: Writes to addresses 11 to 15 change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Staged register contents at `reg_addr` |
| frame_start | input | 1 | Copies staged configuration into the active set |
| in_valid | input | 1 | Input pixel qualifier |
| in_pixel | input | 30 | Input pixel, three 10-bit channels |
| out_valid | output | 1 | Output pixel qualifier |
| out_pixel | output | 30 | Converted or passed-through pixel |

## Verification
The assertions check the cycle-level contracts on every clock. They cover the three-cycle valid delay, bit-exact pass-through whenever the enable in force at capture time was clear, and changes to the active configuration only on a frame-start pulse, when it takes the staged values. They also cover control and shift fields that take the written bits. The numerical behaviour can only be shown by the bench's scenarios, which compare output codes against hand-derived values. This covers the default RGB-to-YCbCr result on primaries and greys, clamping at both ends, negative pre-offsets with floor rounding, extra shift, and the frame-start boundary pixel.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int CSC_CH     = 3;
  localparam int CSC_NCOEF  = CSC_CH * CSC_CH;
  localparam int CSC_HI_LSB = 16;

  // word addresses; the sequence is part of the programming model
  localparam int CSC_ADDR_PRE   = 0;
  localparam int CSC_ADDR_COEF  = CSC_ADDR_PRE + (CSC_CH + 1) / 2;
  localparam int CSC_ADDR_POST  = CSC_ADDR_COEF + (CSC_NCOEF + 1) / 2;
  localparam int CSC_ADDR_MODE  = CSC_ADDR_POST + (CSC_CH + 1) / 2;
  localparam int CSC_ADDR_CTRL  = CSC_ADDR_MODE + 1;
  localparam int CSC_SHIFT_LSB  = 16;

  // even index shares a word with its odd successor and takes the high half;
  // a field left alone in its word sits at bit 0
  function automatic int csc_field_lsb(input int idx, input int count);
    return (((idx % 2) == 0) && ((idx + 1) < count)) ? CSC_HI_LSB : 0;
  endfunction

  // limited-range conversion loaded at reset
  function automatic int csc_default_coef(input int k);
    case (k)
      0: return 186;
      1: return 627;
      2: return 63;
      3: return -102;
      4: return -344;
      5: return 448;
      6: return 448;
      7: return -406;
      8: return -40;
      default: return 0;
    endcase
  endfunction

  function automatic int csc_default_post(input int ch);
    return (ch == 0) ? 64 : 512;
  endfunction

  // add a fixed half-LSB of the fractional part, then floor-divide
  function automatic logic signed [31:0] csc_round_shift(
      input logic signed [31:0] acc, input int frac, input int sh);
    logic signed [31:0] bias;
    bias = 32'sd1 <<< (frac - 1);
    return (acc + bias) >>> (frac + sh);
  endfunction

  function automatic logic [31:0] csc_clamp(input logic signed [31:0] v,
                                            input int maxv);
    if (v < 0)         return 32'd0;
    else if (v > maxv) return 32'(maxv);
    else               return $unsigned(v);
  endfunction

endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int COEF_W  = 13,
  parameter int OFS_W   = 12,
  parameter int SHIFT_W = 3,
  parameter int ADDR_W  = 4,
  parameter int REG_W   = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                reg_wr,
  input  logic [ADDR_W-1:0]                   reg_addr,
  input  logic [REG_W-1:0]                    reg_wdata,
  output logic [REG_W-1:0]                    reg_rdata,
  input  logic                                frame_start,
  output logic [CSC_NCOEF-1:0][COEF_W-1:0]    act_coef,
  output logic [CSC_CH-1:0][OFS_W-1:0]        act_pre,
  output logic [CSC_CH-1:0][OFS_W-1:0]        act_post,
  output logic [SHIFT_W-1:0]                  act_shift,
  output logic                                act_en,
  output logic [SHIFT_W-1:0]                  stg_shift,
  output logic                                stg_en
);

  logic [CSC_NCOEF-1:0][COEF_W-1:0] stg_coef;
  logic [CSC_CH-1:0][OFS_W-1:0]     stg_pre;
  logic [CSC_CH-1:0][OFS_W-1:0]     stg_post;

  logic              coef_hit  [CSC_NCOEF];
  logic [COEF_W-1:0] coef_wval [CSC_NCOEF];
  logic              pre_hit   [CSC_CH];
  logic [OFS_W-1:0]  pre_wval  [CSC_CH];
  logic              post_hit  [CSC_CH];
  logic [OFS_W-1:0]  post_wval [CSC_CH];
  logic              mode_hit;
  logic              ctrl_hit;

  generate
    for (genvar k = 0; k < CSC_NCOEF; k++) begin : g_coef_dec
      localparam int LSB = csc_field_lsb(k, CSC_NCOEF);
      assign coef_hit[k]  = reg_wr && (reg_addr == ADDR_W'(CSC_ADDR_COEF + k / 2));
      assign coef_wval[k] = reg_wdata[LSB +: COEF_W];
    end
    for (genvar c = 0; c < CSC_CH; c++) begin : g_ofs_dec
      localparam int LSB = csc_field_lsb(c, CSC_CH);
      assign pre_hit[c]   = reg_wr && (reg_addr == ADDR_W'(CSC_ADDR_PRE + c / 2));
      assign pre_wval[c]  = reg_wdata[LSB +: OFS_W];
      assign post_hit[c]  = reg_wr && (reg_addr == ADDR_W'(CSC_ADDR_POST + c / 2));
      assign post_wval[c] = reg_wdata[LSB +: OFS_W];
    end
  endgenerate

  assign mode_hit = reg_wr && (reg_addr == ADDR_W'(CSC_ADDR_MODE));
  assign ctrl_hit = reg_wr && (reg_addr == ADDR_W'(CSC_ADDR_CTRL));

  // staged copy, written by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CSC_NCOEF; k++) stg_coef[k] <= COEF_W'(csc_default_coef(k));
      for (int c = 0; c < CSC_CH; c++) begin
        stg_pre[c]  <= '0;
        stg_post[c] <= OFS_W'(csc_default_post(c));
      end
      stg_shift <= '0;
      stg_en    <= 1'b1;
    end else begin
      for (int k = 0; k < CSC_NCOEF; k++)
        if (coef_hit[k]) stg_coef[k] <= coef_wval[k];
      for (int c = 0; c < CSC_CH; c++) begin
        if (pre_hit[c])  stg_pre[c]  <= pre_wval[c];
        if (post_hit[c]) stg_post[c] <= post_wval[c];
      end
      if (mode_hit) stg_shift <= reg_wdata[CSC_SHIFT_LSB +: SHIFT_W];
      if (ctrl_hit) stg_en    <= reg_wdata[0];
    end
  end

  // active copy, seen by the datapath; swapped only on a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CSC_NCOEF; k++) act_coef[k] <= COEF_W'(csc_default_coef(k));
      for (int c = 0; c < CSC_CH; c++) begin
        act_pre[c]  <= '0;
        act_post[c] <= OFS_W'(csc_default_post(c));
      end
      act_shift <= '0;
      act_en    <= 1'b1;
    end else if (frame_start) begin
      act_coef  <= stg_coef;
      act_pre   <= stg_pre;
      act_post  <= stg_post;
      act_shift <= stg_shift;
      act_en    <= stg_en;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < CSC_NCOEF; k++)
      if (reg_addr == ADDR_W'(CSC_ADDR_COEF + k / 2))
        reg_rdata[csc_field_lsb(k, CSC_NCOEF) +: COEF_W] = stg_coef[k];
    for (int c = 0; c < CSC_CH; c++) begin
      if (reg_addr == ADDR_W'(CSC_ADDR_PRE + c / 2))
        reg_rdata[csc_field_lsb(c, CSC_CH) +: OFS_W] = stg_pre[c];
      if (reg_addr == ADDR_W'(CSC_ADDR_POST + c / 2))
        reg_rdata[csc_field_lsb(c, CSC_CH) +: OFS_W] = stg_post[c];
    end
    if (reg_addr == ADDR_W'(CSC_ADDR_MODE)) reg_rdata[CSC_SHIFT_LSB +: SHIFT_W] = stg_shift;
    if (reg_addr == ADDR_W'(CSC_ADDR_CTRL)) reg_rdata[0] = stg_en;
  end

endmodule

// File: rtl/csc_mac_pipe.sv
module csc_mac_pipe
  import csc_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int COEF_W  = 13,
  parameter int OFS_W   = 12,
  parameter int SHIFT_W = 3,
  parameter int FRAC_W  = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [CSC_CH*DATA_W-1:0]         in_pixel,
  input  logic [CSC_NCOEF-1:0][COEF_W-1:0] act_coef,
  input  logic [CSC_CH-1:0][OFS_W-1:0]     act_pre,
  input  logic [CSC_CH-1:0][OFS_W-1:0]     act_post,
  input  logic [SHIFT_W-1:0]               act_shift,
  input  logic                             act_en,
  output logic                             out_valid,
  output logic [CSC_CH*DATA_W-1:0]         out_pixel
);

  localparam int PIX_W    = CSC_CH * DATA_W;
  localparam int OP_W     = ((DATA_W + 1 > OFS_W) ? DATA_W + 1 : OFS_W) + 1;
  localparam int PROD_W   = OP_W + COEF_W;
  localparam int ACC_W    = 32;
  localparam int MAX_CODE = (1 << DATA_W) - 1;

  // stage 0 (combinational): pre-offset add and products
  logic signed [OP_W-1:0]   op   [CSC_CH];
  logic signed [PROD_W-1:0] prod [CSC_NCOEF];

  generate
    for (genvar j = 0; j < CSC_CH; j++) begin : g_op
      assign op[j] = OP_W'($signed({1'b0, in_pixel[(CSC_CH-1-j)*DATA_W +: DATA_W]}))
                   + OP_W'($signed(act_pre[j]));
    end
    for (genvar k = 0; k < CSC_NCOEF; k++) begin : g_mul
      assign prod[k] = PROD_W'($signed(act_coef[k])) * PROD_W'(op[k % CSC_CH]);
    end
  endgenerate

  // stage 1: products plus the configuration that belongs to this pixel
  logic                     s1_valid, s1_en;
  logic [SHIFT_W-1:0]       s1_shift;
  logic [PIX_W-1:0]         s1_pix;
  logic signed [PROD_W-1:0] s1_prod [CSC_NCOEF];
  logic [OFS_W-1:0]         s1_post [CSC_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_en    <= 1'b0;
      s1_shift <= '0;
      s1_pix   <= '0;
      for (int k = 0; k < CSC_NCOEF; k++) s1_prod[k] <= '0;
      for (int c = 0; c < CSC_CH; c++)    s1_post[c] <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_en    <= act_en;
      s1_shift <= act_shift;
      s1_pix   <= in_pixel;
      for (int k = 0; k < CSC_NCOEF; k++) s1_prod[k] <= prod[k];
      for (int c = 0; c < CSC_CH; c++)    s1_post[c] <= act_post[c];
    end
  end

  // stage 2: row sums, rounding and downscale
  logic signed [ACC_W-1:0] acc [CSC_CH];

  always_comb begin
    for (int r = 0; r < CSC_CH; r++) begin
      acc[r] = '0;
      for (int j = 0; j < CSC_CH; j++)
        acc[r] = acc[r] + ACC_W'(s1_prod[r*CSC_CH + j]);
    end
  end

  logic                    s2_valid, s2_en;
  logic [PIX_W-1:0]        s2_pix;
  logic signed [ACC_W-1:0] s2_val  [CSC_CH];
  logic [OFS_W-1:0]        s2_post [CSC_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_en    <= 1'b0;
      s2_pix   <= '0;
      for (int r = 0; r < CSC_CH; r++) begin
        s2_val[r]  <= '0;
        s2_post[r] <= '0;
      end
    end else begin
      s2_valid <= s1_valid;
      s2_en    <= s1_en;
      s2_pix   <= s1_pix;
      for (int r = 0; r < CSC_CH; r++) begin
        s2_val[r]  <= csc_round_shift(acc[r], FRAC_W, int'(s1_shift));
        s2_post[r] <= s1_post[r];
      end
    end
  end

  // stage 3: post-offset, clamp, bypass select
  logic signed [ACC_W-1:0] fin [CSC_CH];
  logic [PIX_W-1:0]        res_pix;

  always_comb begin
    res_pix = '0;
    for (int r = 0; r < CSC_CH; r++) begin
      fin[r] = s2_val[r] + ACC_W'($signed(s2_post[r]));
      res_pix[(CSC_CH-1-r)*DATA_W +: DATA_W] = DATA_W'(csc_clamp(fin[r], MAX_CODE));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= s2_valid;
      out_pixel <= s2_en ? res_pix : s2_pix;
    end
  end

endmodule

// File: rtl/csc_matrix3x3.sv
module csc_matrix3x3
  import csc_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int COEF_W  = 13,
  parameter int OFS_W   = 12,
  parameter int SHIFT_W = 3,
  parameter int FRAC_W  = 10,
  parameter int ADDR_W  = 4,
  parameter int REG_W   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic                       frame_start,
  input  logic                       in_valid,
  input  logic [CSC_CH*DATA_W-1:0]   in_pixel,
  output logic                       out_valid,
  output logic [CSC_CH*DATA_W-1:0]   out_pixel
);

  logic [CSC_NCOEF-1:0][COEF_W-1:0] act_coef;
  logic [CSC_CH-1:0][OFS_W-1:0]     act_pre;
  logic [CSC_CH-1:0][OFS_W-1:0]     act_post;
  logic [SHIFT_W-1:0]               act_shift;
  logic                             act_en;
  logic [SHIFT_W-1:0]               stg_shift;
  logic                             stg_en;

  csc_cfg_regs #(
    .COEF_W (COEF_W),
    .OFS_W  (OFS_W),
    .SHIFT_W(SHIFT_W),
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .frame_start(frame_start),
    .act_coef   (act_coef),
    .act_pre    (act_pre),
    .act_post   (act_post),
    .act_shift  (act_shift),
    .act_en     (act_en),
    .stg_shift  (stg_shift),
    .stg_en     (stg_en)
  );

  csc_mac_pipe #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .OFS_W  (OFS_W),
    .SHIFT_W(SHIFT_W),
    .FRAC_W (FRAC_W)
  ) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_pixel (in_pixel),
    .act_coef (act_coef),
    .act_pre  (act_pre),
    .act_post (act_post),
    .act_shift(act_shift),
    .act_en   (act_en),
    .out_valid(out_valid),
    .out_pixel(out_pixel)
  );

endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk
  import csc_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int SHIFT_W = 3,
  parameter int ADDR_W  = 4,
  parameter int REG_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [REG_W-1:0]         reg_wdata,
  input logic                     frame_start,
  input logic                     in_valid,
  input logic [CSC_CH*DATA_W-1:0] in_pixel,
  input logic                     out_valid,
  input logic [CSC_CH*DATA_W-1:0] out_pixel,
  input logic                     act_en,
  input logic [SHIFT_W-1:0]       act_shift,
  input logic                     stg_en,
  input logic [SHIFT_W-1:0]       stg_shift
);

  // cycles since reset release, saturating at the pipeline depth
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R4
  bypass_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && !$past(act_en, 3)) |-> (out_pixel == $past(in_pixel, 3)));

  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(act_en) && $stable(act_shift)));

  // R7
  active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> ((act_en == $past(stg_en)) && (act_shift == $past(stg_shift))));

  // R5
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CSC_ADDR_CTRL)) |=> (stg_en == $past(reg_wdata[0])));

  // R6
  shift_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(CSC_ADDR_MODE))
      |=> (stg_shift == $past(reg_wdata[CSC_SHIFT_LSB +: SHIFT_W])));

endmodule

bind csc_matrix3x3 csc_matrix_chk #(
  .DATA_W (DATA_W),
  .SHIFT_W(SHIFT_W),
  .ADDR_W (ADDR_W),
  .REG_W  (REG_W)
) u_csc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .frame_start(frame_start),
  .in_valid   (in_valid),
  .in_pixel   (in_pixel),
  .out_valid  (out_valid),
  .out_pixel  (out_pixel),
  .act_en     (act_en),
  .act_shift  (act_shift),
  .stg_en     (stg_en),
  .stg_shift  (stg_shift)
);

// File: tb/test_csc_matrix3x3.sv
module test_csc_matrix3x3;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // r, g, b, expected ch0, ch1, ch2 under the reset programming
  localparam int VEC [NVEC][6] = '{
    '{   0,    0,    0,  64, 512, 512},
    '{1023, 1023, 1023, 939, 514, 514},
    '{1023,    0,    0, 250, 410, 960},
    '{   0, 1023,    0, 690, 168, 106},
    '{   0,    0, 1023, 127, 960, 472},
    '{ 512,  512,  512, 502, 513, 513}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        frame_start;
  logic        in_valid;
  logic [29:0] in_pixel;
  logic        out_valid;
  logic [29:0] out_pixel;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csc_matrix3x3 i_csc_matrix3x3 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .frame_start(frame_start),
    .in_valid   (in_valid),
    .in_pixel   (in_pixel),
    .out_valid  (out_valid),
    .out_pixel  (out_pixel)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic commit();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // drive one pixel and collect it three edges later; latency is checked on the way
  task automatic send(input string req, input int a, input int b, input int c, input bit fs,
                      input int e0, input int e1, input int e2);
    @(negedge clk);
    in_valid = 1'b1; in_pixel = {10'(a), 10'(b), 10'(c)}; frame_start = fs;
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
    @(negedge clk);
    check("R1", "valid before third edge", out_valid, 0);
    @(negedge clk);
    check("R1", "valid at third edge", out_valid, 1);
    check(req, "ch0", out_pixel[29:20], e0);
    check(req, "ch1", out_pixel[19:10], e1);
    check(req, "ch2", out_pixel[9:0],   e2);
    @(negedge clk);
    check("R1", "single valid pulse", out_valid, 0);
  endtask

  // unity matrix, zero offsets, given shift
  task automatic load_identity(input int sh);
    wr_reg(4'd0, 32'h0);
    wr_reg(4'd1, 32'h0);
    wr_reg(4'd2, {16'd1024, 16'd0});
    wr_reg(4'd3, 32'h0);
    wr_reg(4'd4, {16'd1024, 16'd0});
    wr_reg(4'd5, 32'h0);
    wr_reg(4'd6, 32'd1024);
    wr_reg(4'd7, 32'h0);
    wr_reg(4'd8, 32'h0);
    wr_reg(4'd9, 32'(sh) << 16);
    wr_reg(4'd10, 32'd1);
    commit();
  endtask

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    frame_start = 1'b0; in_valid = 1'b0; in_pixel = '0;
    repeat (3) @(negedge clk);
    check("R8", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;

    // R8 / R5: reset programming read back with packing
    rd_reg(4'd0, rd);  check("R8", "pre 0/1", rd, 0);
    rd_reg(4'd2, rd);  check("R8", "coef 00/01", rd, (186 << 16) | 627);
    rd_reg(4'd3, rd);  check("R5", "coef 02/10 signed low half", rd, (63 << 16) | 8090);
    rd_reg(4'd6, rd);  check("R5", "coef 22 alone in low bits", rd, 8152);
    rd_reg(4'd7, rd);  check("R8", "post 0/1", rd, (64 << 16) | 512);
    rd_reg(4'd8, rd);  check("R8", "post 2", rd, 512);
    rd_reg(4'd9, rd);  check("R8", "shift", rd, 0);
    rd_reg(4'd10, rd); check("R8", "enable", rd, 1);

    // R2: default conversion over the vector table
    for (int i = 0; i < NVEC; i++)
      send("R2", VEC[i][0], VEC[i][1], VEC[i][2], 1'b0, VEC[i][3], VEC[i][4], VEC[i][5]);

    // R10: unmapped address is inert
    wr_reg(4'd12, 32'hFFFF_FFFF);
    commit();
    rd_reg(4'd12, rd);  check("R10", "unmapped readback", rd, 0);
    rd_reg(4'd10, rd);  check("R10", "ctrl untouched", rd, 1);
    send("R10", 1023, 0, 0, 1'b0, 250, 410, 960);

    // R7: staged disable has no effect until frame start
    wr_reg(4'd10, 32'd0);
    rd_reg(4'd10, rd);  check("R5", "ctrl staged readback", rd, 0);
    send("R7", 1023, 0, 0, 1'b0, 250, 410, 960);
    send("R7", 1023, 0, 0, 1'b1, 250, 410, 960);  // pixel beside frame_start: old set
    // R4: bypass now active
    send("R4", 1023, 0, 0, 1'b0, 1023, 0, 0);
    send("R4", 17, 600, 999, 1'b0, 17, 600, 999);

    // R2: unity matrix
    load_identity(0);
    send("R2", 300, 700, 1000, 1'b0, 300, 700, 1000);

    // R3: clamp at both ends (post0 = +100, post1 = -100)
    wr_reg(4'd7, {16'd100, 16'd3996});
    commit();
    send("R3", 1000, 50, 5, 1'b0, 1023, 0, 5);

    // R9: signed pre-offsets (-100, +200, -1), post cleared
    wr_reg(4'd7, 32'h0);
    wr_reg(4'd0, {16'd3996, 16'd200});
    wr_reg(4'd1, 32'd4095);
    commit();
    rd_reg(4'd0, rd);  check("R5", "pre 0/1 readback", rd, (3996 << 16) | 200);
    send("R9", 300, 1000, 0, 1'b0, 200, 1023, 0);

    // R6: extra shift of 1 and of 7
    load_identity(1);
    rd_reg(4'd9, rd);  check("R6", "shift field readback", rd, 32'h0001_0000);
    send("R6", 800, 1023, 1, 1'b0, 400, 511, 0);
    load_identity(7);
    send("R6", 800, 1023, 0, 1'b0, 6, 7, 0);

    // R8: reset restores the programming
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    send("R8", 1023, 0, 0, 1'b0, 250, 410, 960);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule